// File: doc/BRIEF.md
# Framed Serial Slave Port with Freshness Flag

This block is the slave side of a serial register port. The serial clock, data-in and frame-select lines arrive from outside without any timing relation to the system clock. The block brings them into the system clock domain, finds the serial clock edges there, and decodes fixed 11-bit frames.

A frame is active while the select line is high. The first bit gives the direction and the second bit picks one of two byte-wide registers. Eight data bits follow, most significant first. The frame closes with one trailing flag bit that the slave drives on the serial output.

The data register is backed by an external receive FIFO. The block sees a "data available" level and the head byte, and it returns a one-cycle pop. The status register is a byte supplied from elsewhere in the device. Writes to the data register go out as a one-cycle strobe toward a transmit path. The transmit path reports when it is full.

Input bits are sampled on rising serial clock edges and the output changes on falling edges. The serial clock must be slow against the system clock: each clock phase must last at least four system clock cycles.

Top module: `framed_spi_slave`

## Requirements
- R1: While the select line is low, and after reset, `sdo_out` is 0 and neither `rx_pop` nor `tx_wr` pulses.
- R2: The first bit sampled in a frame sets the direction (1 = read, 0 = write). The second bit selects the register (0 = data, 1 = status).
- R3: On a read, the eight register bits appear on `sdo_out` most significant first. The first bit is driven on the falling edge that follows the register-select rising edge, and each later bit on the next falling edge.
- R4: On a data-register read, the trailing bit (driven on the falling edge after the eighth data bit) is 0 when the FIFO held data at the select bit. It is 1 otherwise, and in that case the byte sent repeats the last byte that was delivered as new (0x00 after reset).
- R5: A data-register read that reported new data and reached its eleventh rising edge raises `rx_pop` for exactly one system cycle. A stale read never pops.
- R6: A status-register read returns `stat_byte`, sends a trailing 0 and does not pop.
- R7: On a write, eight bits are taken MSB first after the select bit. For the data register, the eleventh rising edge produces a one-cycle `tx_wr` with `tx_byte` equal to that byte.
- R8: On a data-register write, if `tx_full` was high when the eighth data bit was sampled, the trailing bit is 1 and no `tx_wr` is issued. Otherwise the trailing bit is 0.
- R9: A write to the status register issues no `tx_wr` and sends a trailing 0.
- R10: If the select line drops before the eleventh rising edge, the frame is abandoned with no pop, no strobe and no change to the repeated byte. The next frame decodes from its first bit.
- R11: During a write frame `sdo_out` stays 0 except for the trailing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdi_in | input | 1 | Serial data from master, asynchronous |
| csel_in | input | 1 | Frame select, active high, asynchronous |
| sdo_out | output | 1 | Serial data to master |
| rx_avail | input | 1 | Receive FIFO holds unread data |
| rx_byte | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | One-cycle pop of the receive FIFO |
| stat_byte | input | 8 | Status register contents |
| tx_full | input | 1 | Transmit path cannot accept a byte |
| tx_wr | output | 1 | One-cycle write strobe to the transmit path |
| tx_byte | output | 8 | Byte accompanying `tx_wr` |

## Verification
A wrong bit counter shows up as a byte shifted by one position on `sdo_out`, or as a strobe that never comes. Either one is visible within the same frame. A wrong freshness decision appears in the trailing bit and in the pop count at the end of that frame. A wrong repeated-byte register surfaces only on the next stale read, so a stale read is placed right after the new ones. An abort that leaks side effects is exposed by a pop or strobe count that changes before the next complete frame.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;
  typedef enum logic {SEL_DATA = 1'b0, SEL_STAT = 1'b1} sel_e;
endpackage

// File: rtl/fss_sync.sv
module fss_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_i[g]};
      end
      assign lvl_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fss_frame.sv
module fss_frame
  import fss_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = DATA_W + 3,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              sck_rise,
  input  logic              sdi_lvl,
  output logic [CNT_W-1:0]  cnt,
  output dir_e              dir,
  output sel_e              sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              hdr_done,
  output logic              data_done,
  output logic              commit
);
  localparam logic [CNT_W-1:0] C_DIR   = CNT_W'(0);
  localparam logic [CNT_W-1:0] C_SEL   = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_D0    = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_DLAST = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] C_FLAG  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_END   = CNT_W'(FRAME_LEN);

  logic step;
  assign step = cs_lvl && sck_rise && (cnt != C_END);

  always_ff @(posedge clk) begin
    if (rst || !cs_lvl) cnt <= '0;
    else if (step)      cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir     <= DIR_WRITE;
      sel     <= SEL_DATA;
      wr_data <= '0;
    end else if (step) begin
      if (cnt == C_DIR) dir <= dir_e'(sdi_lvl);
      if (cnt == C_SEL) sel <= sel_e'(sdi_lvl);
      if (cnt >= C_D0 && cnt <= C_DLAST)
        wr_data <= {wr_data[DATA_W-2:0], sdi_lvl};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_done  <= 1'b0;
      data_done <= 1'b0;
      commit    <= 1'b0;
    end else begin
      hdr_done  <= step && (cnt == C_SEL);
      data_done <= step && (cnt == C_DLAST);
      commit    <= step && (cnt == C_FLAG);
    end
  end
endmodule

// File: rtl/fss_out.sv
module fss_out #(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = DATA_W + 3,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              sck_fall,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              is_read,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              load_flag,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] C_D0   = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_FLAG = CNT_W'(FRAME_LEN - 1);

  logic [DATA_W:0] pay;
  logic            in_win;
  assign in_win = (cnt >= C_D0) && (cnt <= C_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pay <= '0;
      sdo <= 1'b0;
    end else if (!cs_lvl) begin
      sdo <= 1'b0;
    end else if (load) begin
      pay <= {load_byte, load_flag};
    end else if (sck_fall) begin
      if (!in_win)      sdo <= 1'b0;
      else if (is_read) begin
        sdo <= pay[DATA_W];
        pay <= {pay[DATA_W-1:0], 1'b0};
      end else          sdo <= (cnt == C_FLAG) ? pay[0] : 1'b0;
    end
  end
endmodule

// File: rtl/framed_spi_slave.sv
module framed_spi_slave
  import fss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdi_in,
  input  logic              csel_in,
  output logic              sdo_out,
  input  logic              rx_avail,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_pop,
  input  logic [DATA_W-1:0] stat_byte,
  input  logic              tx_full,
  output logic              tx_wr,
  output logic [DATA_W-1:0] tx_byte
);
  localparam int FRAME_LEN = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [2:0] lvl;
  logic       sck_lvl, sdi_lvl, cs_lvl, sck_prev, sck_rise, sck_fall;

  fss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({csel_in, sdi_in, sclk_in}),
    .lvl_o(lvl)
  );
  assign sck_lvl = lvl[0];
  assign sdi_lvl = lvl[1];
  assign cs_lvl  = lvl[2];

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_lvl;
  end
  assign sck_rise = sck_lvl & ~sck_prev;
  assign sck_fall = ~sck_lvl & sck_prev;

  logic [CNT_W-1:0]  cnt;
  dir_e              dir;
  sel_e              sel;
  logic [DATA_W-1:0] wr_data;
  logic              hdr_done, data_done, commit;

  fss_frame #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .sck_rise(sck_rise), .sdi_lvl(sdi_lvl),
    .cnt(cnt), .dir(dir), .sel(sel), .wr_data(wr_data),
    .hdr_done(hdr_done), .data_done(data_done), .commit(commit)
  );

  logic              rd_fresh, wr_ok, load, load_flag;
  logic [DATA_W-1:0] last_byte, load_byte;
  logic              ld_rd, ld_wr;

  assign ld_rd = hdr_done && (dir == DIR_READ);
  assign ld_wr = data_done && (dir == DIR_WRITE);
  assign load  = ld_rd || ld_wr;

  always_comb begin
    load_byte = '0;
    load_flag = 1'b0;
    if (ld_rd) begin
      if (sel == SEL_STAT) load_byte = stat_byte;
      else begin
        load_byte = rx_avail ? rx_byte : last_byte;
        load_flag = ~rx_avail;
      end
    end else if (ld_wr) begin
      load_flag = (sel == SEL_DATA) && tx_full;
    end
  end

  logic [DATA_W-1:0] rd_hold;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_fresh  <= 1'b0;
      wr_ok     <= 1'b0;
      rd_hold   <= '0;
      last_byte <= '0;
      rx_pop    <= 1'b0;
      tx_wr     <= 1'b0;
      tx_byte   <= '0;
    end else begin
      rx_pop <= 1'b0;
      tx_wr  <= 1'b0;
      if (ld_rd) begin
        rd_fresh <= (sel == SEL_DATA) && rx_avail;
        rd_hold  <= load_byte;
      end
      if (ld_wr) wr_ok <= (sel == SEL_DATA) && !tx_full;
      if (commit && cs_lvl) begin
        if (dir == DIR_READ && sel == SEL_DATA && rd_fresh) begin
          rx_pop    <= 1'b1;
          last_byte <= rd_hold;
        end
        if (dir == DIR_WRITE && wr_ok) begin
          tx_wr   <= 1'b1;
          tx_byte <= wr_data;
        end
      end
    end
  end

  fss_out #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .sck_fall(sck_fall), .cnt(cnt),
    .is_read(dir == DIR_READ), .load(load), .load_byte(load_byte),
    .load_flag(load_flag), .sdo(sdo_out)
  );
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
  input logic clk,
  input logic rst,
  input logic cs_lvl,
  input logic sdo_out,
  input logic rx_pop,
  input logic tx_wr
);
  AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (rst) !cs_lvl |=> !sdo_out); // R1
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst) (rx_pop || tx_wr) |-> $past(cs_lvl)); // R10
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_pop |=> !rx_pop); // R5
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) tx_wr |=> !tx_wr); // R7
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst) !(rx_pop && tx_wr)); // R2
endmodule

bind framed_spi_slave fss_checker u_chk (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .sdo_out(sdo_out),
  .rx_pop(rx_pop), .tx_wr(tx_wr)
);

// File: tb/sim_framed_spi_slave.sv
module sim_framed_spi_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_in = 1'b0, sdi_in = 1'b0, csel_in = 1'b0;
  logic       sdo_out, rx_pop, tx_full = 1'b0, tx_wr, rx_avail;
  logic [7:0] rx_byte, stat_byte = 8'h00, tx_byte;

  always #2.5 clk = ~clk;

  logic [7:0] q [0:3];
  int q_len = 0, head = 0;
  assign rx_avail = head < q_len;
  assign rx_byte  = q[head[1:0]];

  int pops = 0, wrs = 0, checks = 0, fails = 0;
  logic [7:0] last_tx = 8'h00;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (rx_pop) begin pops++; head <= head + 1; end
      if (tx_wr) begin wrs++; last_tx = tx_byte; end
    end
  end

  framed_spi_slave u0 (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdi_in(sdi_in), .csel_in(csel_in),
    .sdo_out(sdo_out), .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .stat_byte(stat_byte), .tx_full(tx_full), .tx_wr(tx_wr), .tx_byte(tx_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs nbits of a frame; returns bits seen on sdo before rises 2..9 and before rise 10.
  task automatic frame(input logic d, input logic s, input logic [7:0] wd, input int nbits,
                       output logic [7:0] rd, output logic flag, output logic any_data_hi);
    logic [10:0] bits;
    bits = {d, s, wd, 1'b0};
    rd = 8'h00; flag = 1'b0; any_data_hi = 1'b0;
    wclk(1); csel_in = 1'b1; wclk(2 * HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi_in = bits[10 - i];
      wclk(HALF);
      if (i >= 2 && i <= 9) begin
        rd = {rd[6:0], sdo_out};
        if (sdo_out) any_data_hi = 1'b1;
      end
      if (i == 10) flag = sdo_out;
      sclk_in = 1'b1; wclk(HALF); sclk_in = 1'b0;
    end
    wclk(HALF); csel_in = 1'b0; wclk(3 * HALF);
  endtask

  logic [7:0] rd; logic fl, hi;

  task automatic t_reset;
    chk("R1 sdo idle", sdo_out, 0);
    chk("R1 no pop", pops, 0);
    chk("R1 no wr", wrs, 0);
  endtask

  task automatic t_read_new;
    frame(1'b1, 1'b0, 8'h00, 11, rd, fl, hi);
    chk("R3 read byte", rd, 8'hA5);
    chk("R4 fresh flag", fl, 0);
    chk("R5 one pop", pops, 1);
    chk("R1 sdo after frame", sdo_out, 0);
    frame(1'b1, 1'b0, 8'h00, 11, rd, fl, hi);
    chk("R3 second byte", rd, 8'h3C);
    chk("R5 second pop", pops, 2);
  endtask

  task automatic t_read_stale;
    frame(1'b1, 1'b0, 8'h00, 11, rd, fl, hi);
    chk("R4 stale repeat", rd, 8'h3C);
    chk("R4 stale flag", fl, 1);
    chk("R5 stale no pop", pops, 2);
  endtask

  task automatic t_read_status;
    stat_byte = 8'h81;
    frame(1'b1, 1'b1, 8'h00, 11, rd, fl, hi);
    chk("R6 status byte", rd, 8'h81);
    chk("R6 status flag", fl, 0);
    chk("R6 no pop", pops, 2);
  endtask

  task automatic t_write;
    frame(1'b0, 1'b0, 8'h5A, 11, rd, fl, hi);
    chk("R7 one strobe", wrs, 1);
    chk("R7 tx byte", last_tx, 8'h5A);
    chk("R8 accept flag", fl, 0);
    chk("R11 sdo quiet in write", hi, 0);
    tx_full = 1'b1;
    frame(1'b0, 1'b0, 8'h77, 11, rd, fl, hi);
    chk("R8 full flag", fl, 1);
    chk("R8 dropped", wrs, 1);
    tx_full = 1'b0;
  endtask

  task automatic t_write_status;
    frame(1'b0, 1'b1, 8'hEE, 11, rd, fl, hi);
    chk("R9 no strobe", wrs, 1);
    chk("R9 flag", fl, 0);
    frame(1'b0, 1'b0, 8'hC3, 11, rd, fl, hi);
    chk("R7 later write", last_tx, 8'hC3);
    chk("R2 write count", wrs, 2);
  endtask

  task automatic t_abort;
    q_len = 3;
    frame(1'b1, 1'b0, 8'h00, 6, rd, fl, hi);
    chk("R10 abort read no pop", pops, 2);
    frame(1'b0, 1'b0, 8'h99, 10, rd, fl, hi);
    chk("R10 abort write no strobe", wrs, 2);
    frame(1'b1, 1'b0, 8'h00, 11, rd, fl, hi);
    chk("R10 next frame byte", rd, 8'hE7);
    chk("R10 next frame flag", fl, 0);
    chk("R10 next frame pop", pops, 3);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    q[0] = 8'hA5; q[1] = 8'h3C; q[2] = 8'hE7; q[3] = 8'h00;
    q_len = 2;
    wclk(5); rst = 1'b0; wclk(5);
    t_reset;
    t_read_new;
    t_read_stale;
    t_read_status;
    t_write;
    t_write_status;
    t_abort;
    done = 1;
    summary;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
    end
  end
endmodule